// File: doc/BRIEF.md
# Interrupt Injector for CPU Core Verification

This peripheral sits on the I/O and memory buses of an 8-bit CPU under test and produces interrupt requests on a schedule that the test program sets up. The program selects an interrupt source and a request width through output ports. A write to the trigger port starts a countdown. When the countdown expires, the request line rises and stays high for the programmed number of cycles.

When the CPU acknowledges the request, the block supplies the instruction it should execute. The block keeps a small vector store, filled by snooping memory writes that fall in a fixed window. Each source owns a slot of four bytes, so the block can feed one-, two- and three-byte instructions over successive acknowledge reads. A write to the verdict port ends the test and records whether it passed.

Top module: `irq_injector`

## Requirements
- R1: A write to I/O port 10h loads the source number from the low SRC_W bits of the written byte; writes to any port other than 10h, 11h, 12h and 20h change nothing.
- R2: A write of n to I/O port 11h, with the write seen in cycle W, raises `irq` first in cycle W+1+n.
- R3: A trigger value of 0 raises `irq` in the cycle right after the write cycle.
- R4: Once raised, `irq` stays high for the number of cycles last written to port 12h; that width is 1 after reset, and a width of 0 acts as 1.
- R5: During acknowledge, `ack_data` shows the vector byte at address 40h + 4*source + index, where the index is the position inside the 4-byte slot.
- R6: Each acknowledge read strobe (`ack_rd` with `inta` high) advances the index by one, and index 3 wraps to 0.
- R7: The index is 0 whenever `inta` is low, and it returns to 0 in the cycle that `irq` rises, even while `inta` stays high.
- R8: A write to I/O port 20h sets `done`; `pass` becomes 1 for the value 55h and 0 for AAh or any other value.
- R9: A trigger write while a countdown or a request is active drops `irq` and restarts the countdown from the new value.
- R10: After reset, `irq`, `done` and `pass` are 0, the source is 0 and the vector store holds zeros.
- R11: Memory writes below 40h or at or above 60h leave the vector store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | Output-port write strobe |
| io_addr | input | 8 | Output-port number |
| io_wdata | input | 8 | Output-port data |
| mem_wr | input | 1 | Memory write strobe (snooped) |
| mem_addr | input | ADDR_W | Memory write address |
| mem_wdata | input | 8 | Memory write data |
| inta | input | 1 | Acknowledge in progress |
| ack_rd | input | 1 | Acknowledge byte read strobe |
| irq | output | 1 | Interrupt request |
| ack_data | output | 8 | Vector byte offered during acknowledge |
| done | output | 1 | Test finished |
| pass | output | 1 | Test passed |

## Verification
The bench measures the exact cycle in which the request first rises for trigger values 0, 1 and 5. A design that counts one register too many or too few would move the edge by a cycle. The bench also measures the request width for the reset default, for a programmed width, and for a width of 0; a design that uses 0 literally would never drop the line or would skip the request. The bench reads a slot through its wrap point and re-arms during an acknowledge that stays high. A design that fails to clear the index would replay the middle of an instruction. It also re-triggers during both a countdown and an active request, where a design without restart would fire at the old time. Finally, it writes just outside the vector window and checks that the slot edges do not change.

// File: rtl/inj_pkg.sv
package inj_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t PORT_SOURCE  = 8'h10;
    localparam byte_t PORT_TRIGGER = 8'h11;
    localparam byte_t PORT_WIDTH   = 8'h12;
    localparam byte_t PORT_VERDICT = 8'h20;

    localparam byte_t CODE_PASS = 8'h55;
    localparam byte_t CODE_FAIL = 8'hAA;

    localparam byte_t WIDTH_RESET = 8'd1;

    typedef struct packed {
        logic  load_src;
        logic  arm;
        logic  load_width;
        logic  finish;
        byte_t value;
    } io_cmd_t;

    typedef struct packed {
        logic done;
        logic pass;
    } verdict_t;

    function automatic verdict_t judge(input byte_t code);
        verdict_t v;
        v.done = 1'b1;
        v.pass = (code == CODE_PASS);
        return v;
    endfunction

    function automatic byte_t eff_width(input byte_t w);
        return (w == '0) ? 8'd1 : w;
    endfunction

endpackage

// File: rtl/inj_io_decode.sv
module inj_io_decode
    import inj_pkg::*;
#(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  byte_t            io_addr,
    input  byte_t            io_wdata,
    output io_cmd_t          cmd,
    output logic [SRC_W-1:0] src_o,
    output byte_t            width_o,
    output verdict_t         verdict_o
);

    logic [SRC_W-1:0] src_q;
    byte_t            width_q;
    verdict_t         verdict_q;

    always_comb begin
        cmd.value      = io_wdata;
        cmd.load_src   = io_wr && (io_addr == PORT_SOURCE);
        cmd.arm        = io_wr && (io_addr == PORT_TRIGGER);
        cmd.load_width = io_wr && (io_addr == PORT_WIDTH);
        cmd.finish     = io_wr && (io_addr == PORT_VERDICT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= '0;
            width_q   <= WIDTH_RESET;
            verdict_q <= '0;
        end else begin
            if (cmd.load_src)   src_q     <= cmd.value[SRC_W-1:0];
            if (cmd.load_width) width_q   <= cmd.value;
            if (cmd.finish)     verdict_q <= judge(cmd.value);
        end
    end

    assign src_o     = src_q;
    assign width_o   = width_q;
    assign verdict_o = verdict_q;

    // R1
    src_load_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_addr == PORT_SOURCE |=> src_o == $past(io_wdata[SRC_W-1:0]));

    // R8
    verdict_pass_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_addr == PORT_VERDICT && io_wdata == CODE_PASS |=> verdict_o.done && verdict_o.pass);

    // R8
    verdict_fail_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_addr == PORT_VERDICT && io_wdata != CODE_PASS |=> verdict_o.done && !verdict_o.pass);

endmodule

// File: rtl/inj_req_timer.sv
module inj_req_timer
    import inj_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  arm,
    input  byte_t arm_val,
    input  byte_t width,
    output logic  irq_o,
    output logic  raise_o
);

    logic  armed_q;
    logic  irq_q;
    byte_t dly_q;
    byte_t wid_q;
    logic  raise;

    // Request rises at the coming edge: immediate trigger, or countdown at its last step.
    always_comb begin
        if (arm) raise = (arm_val == '0);
        else     raise = armed_q && (dly_q == 8'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
            dly_q   <= '0;
            wid_q   <= '0;
        end else if (arm) begin
            armed_q <= (arm_val != '0);
            dly_q   <= arm_val;
            irq_q   <= (arm_val == '0);
            wid_q   <= eff_width(width);
        end else if (armed_q) begin
            if (dly_q == 8'd1) begin
                armed_q <= 1'b0;
                irq_q   <= 1'b1;
                wid_q   <= eff_width(width);
            end else begin
                dly_q <= dly_q - 8'd1;
            end
        end else if (irq_q) begin
            if (wid_q <= 8'd1) irq_q <= 1'b0;
            else               wid_q <= wid_q - 8'd1;
        end
    end

    assign irq_o   = irq_q;
    assign raise_o = raise;

    // R3
    zero_fire_chk: assert property (@(posedge clk) disable iff (rst)
        arm && arm_val == '0 |=> irq_o);

    // R2
    count_fire_chk: assert property (@(posedge clk) disable iff (rst)
        !arm && armed_q && dly_q == 8'd1 |=> irq_o);

    // R9
    rearm_drop_chk: assert property (@(posedge clk) disable iff (rst)
        arm && arm_val != '0 |=> !irq_o);

    // R4
    width_end_chk: assert property (@(posedge clk) disable iff (rst)
        !arm && !armed_q && irq_q && wid_q <= 8'd1 |=> !irq_o);

endmodule

// File: rtl/inj_vector_store.sv
module inj_vector_store
    import inj_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SRC_W      = 3,
    parameter int SLOT_BYTES = 4,
    parameter int BASE       = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  byte_t             mem_wdata,
    input  logic [SRC_W-1:0]  src,
    input  logic              inta,
    input  logic              ack_rd,
    input  logic              restart,
    output byte_t             ack_data
);

    localparam int IDX_W = $clog2(SLOT_BYTES);
    localparam int DEPTH = (1 << SRC_W) * SLOT_BYTES;
    localparam int OFF_W = $clog2(DEPTH);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE + DEPTH);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_BYTES - 1);

    byte_t            cell_q [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic             in_win;
    logic [OFF_W-1:0] wr_off;
    logic [OFF_W-1:0] rd_off;
    logic [ADDR_W:0]  addr_ext;

    assign addr_ext = {1'b0, mem_addr};
    assign in_win   = mem_wr && (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
    assign wr_off   = OFF_W'(addr_ext - WIN_LO);
    assign rd_off   = OFF_W'(src) * OFF_W'(SLOT_BYTES) + OFF_W'(idx_q);

    for (genvar c = 0; c < DEPTH; c++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)                                 cell_q[c] <= '0;
            else if (in_win && wr_off == OFF_W'(c)) cell_q[c] <= mem_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !inta || restart) idx_q <= '0;
        else if (ack_rd)             idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end

    assign ack_data = cell_q[rd_off];

    // R6
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        inta && ack_rd && !restart && idx_q == IDX_LAST |=> idx_q == '0);

    // R7
    idx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !inta || restart |=> idx_q == '0);

endmodule

// File: rtl/irq_injector.sv
module irq_injector
    import inj_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SRC_W      = 3,
    parameter int SLOT_BYTES = 4,
    parameter int VEC_BASE   = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic              inta,
    input  logic              ack_rd,
    output logic              irq,
    output logic [7:0]        ack_data,
    output logic              done,
    output logic              pass
);

    io_cmd_t          cmd;
    logic [SRC_W-1:0] src;
    byte_t            width;
    verdict_t         verdict;
    logic             raise;

    inj_io_decode #(.SRC_W(SRC_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .cmd       (cmd),
        .src_o     (src),
        .width_o   (width),
        .verdict_o (verdict)
    );

    inj_req_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (cmd.arm),
        .arm_val (cmd.value),
        .width   (width),
        .irq_o   (irq),
        .raise_o (raise)
    );

    inj_vector_store #(
        .ADDR_W     (ADDR_W),
        .SRC_W      (SRC_W),
        .SLOT_BYTES (SLOT_BYTES),
        .BASE       (VEC_BASE)
    ) u_vectors (
        .clk       (clk),
        .rst       (rst),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .src       (src),
        .inta      (inta),
        .ack_rd    (ack_rd),
        .restart   (raise),
        .ack_data  (ack_data)
    );

    assign done = verdict.done;
    assign pass = verdict.pass;

    // R8
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

endmodule

// File: tb/tb_irq_injector.sv
module tb_irq_injector;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [7:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        inta;
    logic        ack_rd;
    logic        irq;
    logic [7:0]  ack_data;
    logic        done;
    logic        pass;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_injector dut (
        .clk(clk), .rst(rst),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .inta(inta), .ack_rd(ack_rd),
        .irq(irq), .ack_data(ack_data), .done(done), .pass(pass)
    );

    function automatic logic [7:0] vb(input int off);
        return 8'(8'h3C + off * 7);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    // Called right after a trigger write; sample index k is cycle W+1+k.
    task automatic measure(input string tag, input int exp_dly, input int exp_wid);
        int first = -1;
        int high  = 0;
        for (int k = 0; k < 300; k++) begin
            if (irq) begin
                if (first < 0) first = k;
                high++;
            end else if (first >= 0) begin
                break;
            end
            @(negedge clk);
        end
        check({tag, " delay"}, first, exp_dly);
        check({tag, " width"}, high, exp_wid);
    endtask

    task automatic ack_read(input string tag, input int off);
        check(tag, ack_data, vb(off));
        ack_rd = 1'b1;
        @(negedge clk);
        ack_rd = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 irq", irq, 0);
        check("R10 done", done, 0);
        check("R10 pass", pass, 0);
        inta = 1'b1;
        @(negedge clk);
        check("R10 store zero", ack_data, 0);
        inta = 1'b0;
    endtask

    task automatic t_load;
        for (int o = 0; o < 32; o++) mem_write(16'h0040 + 16'(o), vb(o));
        mem_write(16'h003F, 8'hFF);
        mem_write(16'h0060, 8'hFF);
        inta = 1'b1;
        io_write(8'h10, 8'h00);
        check("R11 slot0 byte0", ack_data, vb(0));
        io_write(8'h10, 8'h07);
        ack_rd = 1'b1;
        repeat (3) @(negedge clk);
        ack_rd = 1'b0;
        check("R11 slot7 byte3", ack_data, vb(31));
        inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_delay_width;
        io_write(8'h11, 8'd0);
        measure("R3 R4 default", 0, 1);
        io_write(8'h11, 8'd1);
        measure("R2 n1", 1, 1);
        io_write(8'h12, 8'd3);
        io_write(8'h11, 8'd5);
        measure("R2 R4 n5 w3", 5, 3);
        io_write(8'h12, 8'd0);
        io_write(8'h11, 8'd2);
        measure("R4 w0", 2, 1);
    endtask

    task automatic t_vector;
        io_write(8'h10, 8'h0D);
        inta = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 4; b++) ack_read("R5 R6 src5", 20 + b);
        check("R6 wrap", ack_data, vb(20));
        io_write(8'h10, 8'h0A);
        check("R1 low bits", ack_data, vb(8));
        inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_index_restart;
        io_write(8'h10, 8'h03);
        inta = 1'b1;
        @(negedge clk);
        ack_read("R5 src3 b0", 12);
        ack_read("R5 src3 b1", 13);
        io_write(8'h11, 8'd0);
        check("R7 raise clears", ack_data, vb(12));
        ack_read("R7 after raise b0", 12);
        ack_read("R7 after raise b1", 13);
        inta = 1'b0;
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        check("R7 new ack", ack_data, vb(12));
        inta = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_retrigger;
        io_write(8'h12, 8'd2);
        io_write(8'h11, 8'd6);
        repeat (2) @(negedge clk);
        io_write(8'h11, 8'd3);
        measure("R9 during delay", 3, 2);
        io_write(8'h12, 8'd10);
        io_write(8'h11, 8'd0);
        @(negedge clk);
        check("R9 high before", irq, 1);
        io_write(8'h11, 8'd2);
        measure("R9 during width", 2, 10);
    endtask

    task automatic t_ignored;
        io_write(8'h12, 8'd1);
        io_write(8'h10, 8'h04);
        io_write(8'h13, 8'h09);
        io_write(8'h21, 8'h55);
        check("R1 other port done", done, 0);
        inta = 1'b1;
        @(negedge clk);
        check("R1 other port src", ack_data, vb(16));
        inta = 1'b0;
        io_write(8'h11, 8'd0);
        measure("R1 other port width", 0, 1);
    endtask

    task automatic t_verdict;
        io_write(8'h20, 8'h77);
        check("R8 other done", done, 1);
        check("R8 other pass", pass, 0);
        io_write(8'h20, 8'h55);
        check("R8 55 done", done, 1);
        check("R8 55 pass", pass, 1);
        io_write(8'h20, 8'hAA);
        check("R8 AA done", done, 1);
        check("R8 AA pass", pass, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        io_wr = 1'b0; io_addr = '0; io_wdata = '0;
        mem_wr = 1'b0; mem_addr = '0; mem_wdata = '0;
        inta = 1'b0; ack_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_delay_width();
        t_vector();
        t_index_restart();
        t_retrigger();
        t_ignored();
        t_verdict();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule